// File: doc/BRIEF.md
# Gate Driver Supply and Enable Supervisor

This block sits beside the gate sequencer of a synchronous half-bridge driver. Each clock it reads five sampled comparator flags: pre-protection level reached, supply above the rising start level, supply below the falling level, switch node above the overvoltage trip level, and the external enable level. From these it decides whether the sequencer may switch. It can also force the low-side switch on, ask for the shared enable line to be pulled low, and report that an enable calibration is running.

It covers three functions. The first is undervoltage lockout with hysteresis between two comparator levels. The second is a pre-overvoltage latch: if the switch node is high during startup, the latch turns the low-side switch on, and only a full supply power cycle releases it. The third is a calibration hold-off after every enable rising edge. The calibration itself is modelled as a timer of `CAL_CYCLES` clock cycles.

Top module: `drvsup_supervisor`

## Requirements
- R1: While reset is held and on release, `enableOk` and `lowSideForce` are 0, `calBusy` is 0 and `enPullDown` is 1, because lockout starts active.
- R2: Lockout clears on the clock edge that samples `supStartOk`=1 with `supBelowFall`=0. From the following cycle, `enPullDown` is 0 unless the overvoltage latch is set.
- R3: Hysteresis: when both `supStartOk` and `supBelowFall` are 0, the lockout state is kept. `supBelowFall`=1 sets lockout at the next edge and takes priority over `supStartOk`.
- R4: `enPullDown` is 1 whenever lockout is active or the overvoltage latch is set.
- R5: While the startup window is open and `supPreOk`=1, sampling `swOverVolt`=1 sets the overvoltage latch, so `lowSideForce` is 1 from the next cycle.
- R6: `swOverVolt` has no effect while `supPreOk`=0 or after the startup window has closed.
- R7: Once set, the latch stays set until `supBelowFall`=1 has been sampled and `supStartOk`=1 is sampled afterwards. If `swOverVolt` is still 1 at that point, the latch sets again.
- R8: The edge that first samples `enLevel`=1 after it was 0 starts a calibration. `calBusy` is then 1 for exactly `CAL_CYCLES` cycles.
- R9: `enableOk` is 1 exactly when lockout is clear, the latch is clear, `enLevel`=1 and a calibration has completed. Completion is forgotten when `enLevel` is 0 or `supBelowFall`=1 is sampled.
- R10: `enLevel`=0 during calibration aborts it, and `calBusy` is 0 from the next cycle. The next rising edge runs a full `CAL_CYCLES` interval again.
- R11: The startup window opens at reset and whenever `supBelowFall`=1 is sampled. It closes when a calibration completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| supPreOk | input | 1 | Supply above pre-protection level |
| supStartOk | input | 1 | Supply above rising start level |
| supBelowFall | input | 1 | Supply below falling lockout level |
| swOverVolt | input | 1 | Switch node above overvoltage trip level |
| enLevel | input | 1 | Sampled external enable level |
| enableOk | output | 1 | Sequencer may follow the PWM command |
| lowSideForce | output | 1 | Force low-side switch on (overvoltage latch) |
| enPullDown | output | 1 | Request to pull the enable line low |
| calBusy | output | 1 | Calibration interval in progress |

## Verification
The bench builds the block with `CAL_CYCLES` set to 8. This lets it count every calibration cycle one by one, including aborted and restarted intervals, within a short run. It also sweeps every combination of the two supply-level flags from both lockout states. The overvoltage latch is walked through set, an attempted release without a power cycle, a relatch while the switch node is still high, and a clean release.

// File: rtl/drvsup_pkg.sv
package drvsup_pkg;
  typedef struct packed {
    logic calStart;
    logic calAbort;
  } calStrobe_t;
endpackage

// File: rtl/drvsup_caltimer.sv
module drvsup_caltimer
  import drvsup_pkg::*;
#(
  parameter int CAL_CYCLES = 6_000_000
) (
  input  logic       clk,
  input  logic       rstN,
  input  calStrobe_t strb,
  output logic       calBusy,
  output logic       calExpire
);
  localparam int CNT_W = $clog2(CAL_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CAL_CYCLES - 1);

  logic             active;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (strb.calAbort) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (strb.calStart) begin
      active <= 1'b1;
      cnt    <= '0;
    end else if (active) begin
      if (cnt == LAST) active <= 1'b0;
      else             cnt    <= cnt + 1'b1;
    end
  end

  assign calBusy   = active;
  assign calExpire = active && (cnt == LAST) && !strb.calAbort && !strb.calStart;

  // R10: an abort strobe ends the interval on the next cycle
  assert_abort_stops_R10: assert property (@(posedge clk) disable iff (!rstN)
    strb.calAbort |=> !calBusy);
  // R8: a start strobe always yields a busy interval
  assert_start_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strb.calStart && !strb.calAbort) |=> calBusy);
endmodule

// File: rtl/drvsup_ctrl.sv
module drvsup_ctrl
  import drvsup_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       supPreOk,
  input  logic       supStartOk,
  input  logic       supBelowFall,
  input  logic       swOverVolt,
  input  logic       enLevel,
  input  logic       calExpire,
  output calStrobe_t strb,
  output logic       enableOk,
  output logic       lowSideForce,
  output logic       enPullDown
);
  logic uvLock;
  logic ovpLatch;
  logic pcArm;
  logic startupDone;
  logic calDone;
  logic enPrev;
  logic enRise;
  logic windowOpen;
  logic ovpTrip;

  assign enRise     = enLevel && !enPrev;
  assign windowOpen = supPreOk && !startupDone;
  assign ovpTrip    = windowOpen && swOverVolt;

  always_comb begin
    strb.calAbort = !enLevel || supBelowFall;
    strb.calStart = enRise && !strb.calAbort;
  end

  // undervoltage lockout with hysteresis
  always_ff @(posedge clk) begin
    if (!rstN)             uvLock <= 1'b1;
    else if (supBelowFall) uvLock <= 1'b1;
    else if (supStartOk)   uvLock <= 1'b0;
  end

  // pre-overvoltage latch, released only by a power cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovpLatch <= 1'b0;
      pcArm    <= 1'b0;
    end else if (ovpTrip) begin
      ovpLatch <= 1'b1;
      pcArm    <= 1'b0;
    end else if (ovpLatch) begin
      if (supBelowFall)            pcArm <= 1'b1;
      else if (pcArm && supStartOk) begin
        ovpLatch <= 1'b0;
        pcArm    <= 1'b0;
      end
    end
  end

  // startup window and calibration completion
  always_ff @(posedge clk) begin
    if (!rstN) begin
      startupDone <= 1'b0;
      calDone     <= 1'b0;
      enPrev      <= 1'b0;
    end else begin
      enPrev <= enLevel;
      if (supBelowFall)   startupDone <= 1'b0;
      else if (calExpire) startupDone <= 1'b1;
      if (strb.calAbort || strb.calStart) calDone <= 1'b0;
      else if (calExpire)                 calDone <= 1'b1;
    end
  end

  assign enableOk     = !uvLock && !ovpLatch && enLevel && calDone;
  assign lowSideForce = ovpLatch;
  assign enPullDown   = uvLock || ovpLatch;

  // R3: a falling-level sample always yields lockout next cycle
  assert_below_locks_R3: assert property (@(posedge clk) disable iff (!rstN)
    supBelowFall |=> enPullDown && !enableOk);
  // R7: the latch cannot release while no start sample follows
  assert_latch_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    (lowSideForce && !supStartOk) |=> lowSideForce);
  // R5: a trip inside the window forces the low side
  assert_trip_forces_R5: assert property (@(posedge clk) disable iff (!rstN)
    ovpTrip |=> lowSideForce && enPullDown);
  // R9: never enabled while forcing low side
  assert_force_excl_R9: assert property (@(posedge clk) disable iff (!rstN)
    lowSideForce |-> !enableOk);
  // R9: enable low drops enable-ok at once
  assert_en_low_off_R9: assert property (@(posedge clk) disable iff (!rstN)
    !enLevel |-> !enableOk);
endmodule

// File: rtl/drvsup_supervisor.sv
module drvsup_supervisor
  import drvsup_pkg::*;
#(
  parameter int CAL_CYCLES = 6_000_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic supPreOk,
  input  logic supStartOk,
  input  logic supBelowFall,
  input  logic swOverVolt,
  input  logic enLevel,
  output logic enableOk,
  output logic lowSideForce,
  output logic enPullDown,
  output logic calBusy
);
  calStrobe_t strb;
  logic       calExpire;

  drvsup_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .supPreOk     (supPreOk),
    .supStartOk   (supStartOk),
    .supBelowFall (supBelowFall),
    .swOverVolt   (swOverVolt),
    .enLevel      (enLevel),
    .calExpire    (calExpire),
    .strb         (strb),
    .enableOk     (enableOk),
    .lowSideForce (lowSideForce),
    .enPullDown   (enPullDown)
  );

  drvsup_caltimer #(.CAL_CYCLES(CAL_CYCLES)) u_cal (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .calBusy   (calBusy),
    .calExpire (calExpire)
  );

  // R8: calibration and switching are mutually exclusive
  assert_busy_excl_R8: assert property (@(posedge clk) disable iff (!rstN)
    calBusy |-> !enableOk);
endmodule

// File: tb/test_drvsup_supervisor.sv
module test_drvsup_supervisor;
  localparam int CAL = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic supPreOk = 1'b0, supStartOk = 1'b0, supBelowFall = 1'b1;
  logic swOverVolt = 1'b0, enLevel = 1'b0;
  logic enableOk, lowSideForce, enPullDown, calBusy;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  drvsup_supervisor #(.CAL_CYCLES(CAL)) i_drvsup_supervisor (
    .clk(clk), .rstN(rstN), .supPreOk(supPreOk), .supStartOk(supStartOk),
    .supBelowFall(supBelowFall), .swOverVolt(swOverVolt), .enLevel(enLevel),
    .enableOk(enableOk), .lowSideForce(lowSideForce),
    .enPullDown(enPullDown), .calBusy(calBusy)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  // R8 R9: enable rising edge, then count the busy interval cycle by cycle
  task automatic calRun(input string req, input logic expOk);
    enLevel = 1'b1;
    for (int k = 1; k <= CAL + 1; k++) begin
      step(1);
      chk(req, "calBusy", calBusy, k <= CAL);
      chk(req, "enableOk", enableOk, (k > CAL) && expOk);
    end
  endtask

  initial begin
    step(2);
    chk("R1", "enPullDown", enPullDown, 1'b1);
    chk("R1", "enableOk", enableOk, 1'b0);
    chk("R1", "lowSideForce", lowSideForce, 1'b0);
    chk("R1", "calBusy", calBusy, 1'b0);
    rstN = 1'b1;
    step(1);
    chk("R1", "enPullDown after release", enPullDown, 1'b1);

    // R6: overvoltage ignored while below pre-protection level
    swOverVolt = 1'b1;
    step(2);
    chk("R6", "lowSideForce pre low", lowSideForce, 1'b0);
    swOverVolt = 1'b0;

    // R2 R3: sweep the level flags from both lockout states
    supPreOk = 1'b1;
    for (int s = 0; s < 2; s++) begin
      for (int c = 0; c < 4; c++) begin
        supBelowFall = (s == 0); supStartOk = (s == 1);
        step(1);
        supStartOk = c[0]; supBelowFall = c[1];
        step(1);
        chk(c[1] ? "R3" : (c[0] ? "R2" : "R3"), "enPullDown sweep", enPullDown,
            c[1] ? 1'b1 : (c[0] ? 1'b0 : (s == 0)));
      end
    end
    supBelowFall = 1'b0; supStartOk = 1'b1;
    step(1);
    chk("R2", "lock cleared", enPullDown, 1'b0);
    supStartOk = 1'b0;
    step(3);
    chk("R3", "hysteresis band holds", enPullDown, 1'b0);

    // R8 R9 R11: first calibration closes the window
    calRun("R8", 1'b1);
    swOverVolt = 1'b1;
    step(2);
    chk("R11", "no trip after window", lowSideForce, 1'b0);
    chk("R6", "still enabled", enableOk, 1'b1);
    swOverVolt = 1'b0;

    // R10: abort and full restart
    enLevel = 1'b0;
    step(1);
    chk("R9", "enable low", enableOk, 1'b0);
    enLevel = 1'b1;
    step(3);
    chk("R10", "busy mid", calBusy, 1'b1);
    enLevel = 1'b0;
    step(1);
    chk("R10", "aborted", calBusy, 1'b0);
    calRun("R10", 1'b1);

    // R3 R11: power drop reopens the window and forgets calibration
    supBelowFall = 1'b1;
    step(1);
    chk("R3", "relock", enPullDown, 1'b1);
    chk("R9", "off when locked", enableOk, 1'b0);
    supBelowFall = 1'b0; supStartOk = 1'b1;
    step(1);
    chk("R9", "calibration forgotten", enableOk, 1'b0);
    swOverVolt = 1'b1;
    step(1);
    chk("R5", "latched", lowSideForce, 1'b1);
    chk("R4", "pulldown on latch", enPullDown, 1'b1);
    swOverVolt = 1'b0;

    // R7: no release without the falling level
    supStartOk = 1'b0; step(1); supStartOk = 1'b1; step(3);
    chk("R7", "held without power cycle", lowSideForce, 1'b1);
    supBelowFall = 1'b1; supStartOk = 1'b0; step(2);
    supBelowFall = 1'b0; supStartOk = 1'b1; swOverVolt = 1'b1; step(2);
    chk("R7", "relatch on overvoltage", lowSideForce, 1'b1);
    swOverVolt = 1'b0;
    supBelowFall = 1'b1; supStartOk = 1'b0; step(1);
    supBelowFall = 1'b0; supStartOk = 1'b1; step(2);
    chk("R7", "released", lowSideForce, 1'b0);
    chk("R4", "pulldown released", enPullDown, 1'b0);
    chk("R9", "needs new edge", enableOk, 1'b0);
    enLevel = 1'b0;
    step(1);
    calRun("R9", 1'b1);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end
endmodule